// File: doc/BRIEF.md
# Three-level reference vector reducer

This block turns one sampled reference voltage vector of a three-level inverter into a two-level modulation problem. The plane of reachable three-level vectors is treated as six small two-level hexagons. Each one is centred on a vertex of the inner hexagon. The block picks one of them, moves the origin of the reference to that hexagon's centre, and then applies ordinary two-level space-vector arithmetic to the moved vector. The result is the hexagon index, the two-level sector and the dwell times of the two active vectors and the zero vector, all in timer ticks.

The reference arrives as signed fixed-point alpha and beta values. The unit is `2^F` counts, which equals one third of the DC-link voltage. That unit is both the distance from the origin to each hexagon centre and the length of every two-level active vector. The block uses no trigonometric function. Every angle decision is a sign test on alpha combined with beta scaled by a fixed-point square root of three.

Where two neighbouring hexagons overlap, either index is valid. The nearest hexagon by angle is the default. An override request selects the neighbour on the reference's side, and it takes effect only if the reference actually lies inside that neighbour. Each result appears three clocks after its input strobe. A new input may be given on every clock.

Top module: `tl_svm_reducer`

## Requirements
- R1: Hexagon index k (1..6) has its centre at angle 60*(k-1) degrees and distance U = 2^F from the origin. With no override, the chosen index is the hexagon whose centre is angularly nearest the reference, so hexagon k covers angles from 60*(k-1)-30 to 60*(k-1)+30 degrees.
- R2: When `alt_sel` is 1 and the reference lies inside the neighbouring hexagon on its side of the chosen centre, the neighbour's index is output instead. The neighbour is k+1 when the reference is counter-clockwise of centre k and k-1 otherwise, wrapping between 6 and 1.
- R3: When `alt_sel` is 1 but the reference is outside that neighbouring hexagon, the request has no effect and the nearest index from R1 is output.
- R4: The corrected reference is the input minus the centre of the chosen hexagon. `sector` s (1..6) is the 60-degree slice of the corrected vector's angle from 60*(s-1) to 60*s degrees.
- R5: `t_a` is the dwell of the active vector at 60*(s-1) degrees and `t_b` is the dwell of the vector at 60*s degrees. Both come from the two-level decomposition of the corrected vector, scaled so that a corrected vector of length U along an active vector gives T_S ticks. They are accurate to within 3 ticks.
- R6: `t_z` equals T_S - `t_a` - `t_b` when that value is positive, and 0 otherwise.
- R7: `done` is a one-cycle pulse exactly three clocks after each `in_valid`. Strobes on consecutive clocks produce results on consecutive clocks, in order.
- R8: Between `done` pulses, all result outputs hold their values. Input changes without `in_valid` have no effect on them.
- R9: After reset, `done`, `hex_idx`, `sector`, `t_a`, `t_b` and `t_z` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Reference sample strobe |
| ref_alpha | input | W | Signed alpha component, 2^F counts = one third of DC link |
| ref_beta | input | W | Signed beta component, same scale |
| alt_sel | input | 1 | Request the adjacent legal hexagon in an overlap |
| hex_idx | output | 3 | Chosen hexagon, 1..6 |
| sector | output | 3 | Two-level sector of the corrected vector, 1..6 |
| t_a | output | TW | Dwell of the leading active vector, ticks |
| t_b | output | TW | Dwell of the trailing active vector, ticks |
| t_z | output | TW | Zero-vector dwell, ticks |
| done | output | 1 | Result valid pulse |

## Verification
The following properties are checked on every cycle:
- the three-clock latency from strobe to result;
- that results hold between pulses;
- that the index and the sector stay in 1..6;
- that the three dwell times sum to T_S whenever the zero time is not saturated.

Whether the index, sector and dwell values are geometrically right can only be shown by the bench's scenarios, which compare against a floating-point model. The same holds for the following, each of which depends on where a particular reference lies:
- the override being taken inside an overlap;
- the override being refused outside one;
- zero-time saturation for a reference beyond the chosen hexagon.

// File: rtl/tl_svm_reducer.sv
module tl_svm_reducer #(
  parameter int W  = 16,
  parameter int F  = 10,
  parameter int TS = 1000,
  parameter int TW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic signed [W-1:0] ref_alpha,
  input  logic signed [W-1:0] ref_beta,
  input  logic                alt_sel,
  output logic [2:0]          hex_idx,
  output logic [2:0]          sector,
  output logic [TW-1:0]       t_a,
  output logic [TW-1:0]       t_b,
  output logic [TW-1:0]       t_z,
  output logic                done
);
  localparam int U   = 1 << F;
  localparam int CW  = W + 4;
  localparam int PW  = W + 12;
  localparam int DEN = 3 * U;
  localparam logic signed [CW-1:0] LIM_B = CW'(3 * U / 2);
  localparam logic signed [CW-1:0] LIM_S = CW'(3 * U);

  function automatic logic signed [CW-1:0] cen_a(input logic [2:0] k);
    case (k)
      3'd1:    return CW'(U);
      3'd2:    return CW'(U / 2);
      3'd3:    return CW'(-U / 2);
      3'd4:    return CW'(-U);
      3'd5:    return CW'(-U / 2);
      default: return CW'(U / 2);
    endcase
  endfunction

  function automatic logic signed [CW-1:0] cen_b(input logic [2:0] k);
    case (k)
      3'd1, 3'd4: return '0;
      3'd2, 3'd3: return CW'(3 * U / 2);
      default:    return CW'(-3 * U / 2);
    endcase
  endfunction

  function automatic logic inside_hex(input logic [2:0] k,
                                      input logic signed [CW-1:0] a,
                                      input logic signed [CW-1:0] b);
    logic signed [CW-1:0] da, db, s, d;
    da = a - cen_a(k);
    db = b - cen_b(k);
    s  = (da <<< 1) + da + db;
    d  = (da <<< 1) + da - db;
    return (db <= LIM_B) && (db >= -LIM_B) && (s <= LIM_S) && (s >= -LIM_S) &&
           (d <= LIM_S) && (d >= -LIM_S);
  endfunction

  function automatic logic [TW-1:0] to_ticks(input logic signed [CW-1:0] n);
    logic [63:0] m, q;
    if (n <= 0) return '0;
    m = {{(64-CW){1'b0}}, n} * 64'(TS);
    q = m / 64'(DEN);
    if (q > 64'((1 << TW) - 1)) return '1;
    return q[TW-1:0];
  endfunction

  // stage 0: scale beta, pick hexagon
  logic signed [CW-1:0] ax, b3, u, v, p, q;
  logic signed [PW-1:0] beta_x, bprod;
  logic [2:0] prim, nb, sel;

  assign ax     = {{(CW-W){ref_alpha[W-1]}}, ref_alpha};
  assign beta_x = {{(PW-W){ref_beta[W-1]}}, ref_beta};
  assign bprod  = beta_x * $signed(PW'(1774));
  assign b3     = CW'(bprod >>> 10);
  assign u = ax - b3;
  assign v = ax + b3;
  assign p = (ax <<< 1) + ax - b3;
  assign q = (ax <<< 1) + ax + b3;

  always_comb begin
    if (u > 0 && v > 0)        prim = 3'd1;
    else if (u <= 0 && v <= 0) prim = 3'd4;
    else if (v > 0)            prim = (ax > 0) ? 3'd2 : 3'd3;
    else                       prim = (ax > 0) ? 3'd6 : 3'd5;
    case (prim)
      3'd1:    nb = (b3 >= 0) ? 3'd2 : 3'd6;
      3'd2:    nb = (p > 0)   ? 3'd1 : 3'd3;
      3'd3:    nb = (q > 0)   ? 3'd2 : 3'd4;
      3'd4:    nb = (b3 >= 0) ? 3'd3 : 3'd5;
      3'd5:    nb = (p > 0)   ? 3'd6 : 3'd4;
      default: nb = (q > 0)   ? 3'd1 : 3'd5;
    endcase
  end
  assign sel = (alt_sel && inside_hex(nb, ax, b3)) ? nb : prim;

  logic                 r1_v, r2_v;
  logic [2:0]           r1_hex, r2_hex, r2_sec;
  logic signed [CW-1:0] r1_a, r1_b, r2_n1, r2_n2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1_v <= 1'b0; r1_hex <= '0; r1_a <= '0; r1_b <= '0;
    end else begin
      r1_v <= in_valid;
      if (in_valid) begin
        r1_hex <= sel;
        r1_a   <= ax - cen_a(sel);
        r1_b   <= b3 - cen_b(sel);
      end
    end
  end

  // stage 1: sector and active-vector numerators
  logic signed [CW-1:0] xx, yy, zz, n1, n2;
  logic [2:0] sec;
  assign xx = r1_b <<< 1;
  assign yy = (r1_a <<< 1) + r1_a + r1_b;
  assign zz = r1_b - (r1_a <<< 1) - r1_a;

  always_comb begin
    if (r1_b >= 0) sec = (zz < 0) ? 3'd1 : (yy > 0) ? 3'd2 : 3'd3;
    else           sec = (yy > 0) ? 3'd6 : (zz < 0) ? 3'd5 : 3'd4;
    case (sec)
      3'd1:    begin n1 = -zz; n2 = xx;  end
      3'd2:    begin n1 = yy;  n2 = zz;  end
      3'd3:    begin n1 = xx;  n2 = -yy; end
      3'd4:    begin n1 = zz;  n2 = -xx; end
      3'd5:    begin n1 = -yy; n2 = -zz; end
      default: begin n1 = -xx; n2 = yy;  end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r2_v <= 1'b0; r2_hex <= '0; r2_sec <= '0; r2_n1 <= '0; r2_n2 <= '0;
    end else begin
      r2_v <= r1_v;
      if (r1_v) begin
        r2_hex <= r1_hex;
        r2_sec <= sec;
        r2_n1  <= n1;
        r2_n2  <= n2;
      end
    end
  end

  // stage 2: ticks and zero time
  logic [TW-1:0] ta_n, tb_n;
  logic [TW:0]   tsum;
  assign ta_n = to_ticks(r2_n1);
  assign tb_n = to_ticks(r2_n2);
  assign tsum = {1'b0, ta_n} + {1'b0, tb_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0; hex_idx <= '0; sector <= '0; t_a <= '0; t_b <= '0; t_z <= '0;
    end else begin
      done <= r2_v;
      if (r2_v) begin
        hex_idx <= r2_hex;
        sector  <= r2_sec;
        t_a     <= ta_n;
        t_b     <= tb_n;
        t_z     <= (tsum >= (TW+1)'(TS)) ? '0 : TW'((TW+1)'(TS) - tsum);
      end
    end
  end
endmodule

module tl_svm_reducer_chk #(
  parameter int TS = 1000,
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [2:0]    hex_idx,
  input logic [2:0]    sector,
  input logic [TW-1:0] t_a,
  input logic [TW-1:0] t_b,
  input logic [TW-1:0] t_z,
  input logic          done
);
  // R7
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_valid, 3));
  // R7
  valid_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 done);
  // R1
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (hex_idx >= 3'd1 && hex_idx <= 3'd6));
  // R4
  sector_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sector >= 3'd1 && sector <= 3'd6));
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(hex_idx) && $stable(sector) && $stable(t_a) && $stable(t_b) && $stable(t_z)));
  // R6
  dwell_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && t_z != '0) |-> ({2'b0, t_a} + {2'b0, t_b} + {2'b0, t_z} == (TW+2)'(TS)));
endmodule

bind tl_svm_reducer tl_svm_reducer_chk #(.TS(TS), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .hex_idx(hex_idx), .sector(sector),
  .t_a(t_a), .t_b(t_b), .t_z(t_z), .done(done)
);

// File: tb/tl_svm_reducer_bench.sv
module tl_svm_reducer_bench;
  localparam int  TW = 16;
  localparam real UR = 1024.0;
  localparam real TSR = 1000.0;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, alt_sel = 1'b0;
  logic signed [15:0] ref_alpha = '0, ref_beta = '0;
  logic [2:0] hex_idx, sector;
  logic [TW-1:0] t_a, t_b, t_z;
  logic done;
  int checks = 0, errors = 0;

  tl_svm_reducer u_tl_svm_reducer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ref_alpha(ref_alpha), .ref_beta(ref_beta),
    .alt_sel(alt_sel), .hex_idx(hex_idx), .sector(sector), .t_a(t_a), .t_b(t_b), .t_z(t_z),
    .done(done)
  );

  always #2 clk = ~clk;

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int rnd(input real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  function automatic real ang(input real y, input real x);
    real t;
    t = $atan2(y, x) * 180.0 / PI;
    if (t < 0.0) t = t + 360.0;
    return t;
  endfunction

  task automatic model(input int ia, input int ib, input bit alt,
                       output int ehex, output int esec, output real t1, output real t2, output real tz);
    real th, off, ca, cb, da, db, phi, x, y, s3, rd;
    int k, nb, s;
    s3 = $sqrt(3.0);
    th = ang(real'(ib), real'(ia));
    k  = ($rtoi((th + 30.0) / 60.0) % 6) + 1;
    off = th - 60.0 * (k - 1);
    if (off > 180.0) off = off - 360.0;
    nb = (off >= 0.0) ? (k % 6) + 1 : ((k + 4) % 6) + 1;
    rd = 60.0 * (nb - 1) * PI / 180.0;
    da = (real'(ia) - UR * $cos(rd)) / UR;
    db = (real'(ib) - UR * $sin(rd)) / UR;
    if (alt && (db <= s3 / 2.0) && (db >= -s3 / 2.0) &&
        (s3 * da + db <= s3) && (s3 * da + db >= -s3) &&
        (s3 * da - db <= s3) && (s3 * da - db >= -s3)) k = nb;
    rd = 60.0 * (k - 1) * PI / 180.0;
    da = real'(ia) - UR * $cos(rd);
    db = real'(ib) - UR * $sin(rd);
    phi = ang(db, da);
    s = $rtoi(phi / 60.0) + 1;
    if (s > 6) s = 6;
    rd = 60.0 * (s - 1) * PI / 180.0;
    x = da * $cos(rd) + db * $sin(rd);
    y = -da * $sin(rd) + db * $cos(rd);
    t1 = TSR * (x - y / s3) / UR;
    t2 = TSR * 2.0 * y / (s3 * UR);
    tz = TSR - t1 - t2;
    if (tz < 0.0) tz = 0.0;
    ehex = k;
    esec = s;
  endtask

  task automatic drive(input real mag, input real deg, input bit alt, output int ia, output int ib);
    ia = rnd(mag * UR * $cos(deg * PI / 180.0));
    ib = rnd(mag * UR * $sin(deg * PI / 180.0));
    ref_alpha = 16'(ia);
    ref_beta  = 16'(ib);
    alt_sel   = alt;
    in_valid  = 1'b1;
  endtask

  task automatic compare(input int ia, input int ib, input bit alt, input string htag);
    int eh, es;
    real e1, e2, ez;
    model(ia, ib, alt, eh, es, e1, e2, ez);
    chk(done == 1'b1, "R7", "done pulse", int'(done), 1);
    chk(int'(hex_idx) == eh, htag, "hex_idx", int'(hex_idx), eh);
    chk(int'(sector) == es, "R4", "sector", int'(sector), es);
    chk((int'(t_a) - rnd(e1) <= 3) && (rnd(e1) - int'(t_a) <= 3), "R5", "t_a", int'(t_a), rnd(e1));
    chk((int'(t_b) - rnd(e2) <= 3) && (rnd(e2) - int'(t_b) <= 3), "R5", "t_b", int'(t_b), rnd(e2));
    chk((int'(t_z) - rnd(ez) <= 3) && (rnd(ez) - int'(t_z) <= 3), "R6", "t_z", int'(t_z), rnd(ez));
  endtask

  task automatic run_point(input real mag, input real deg, input bit alt, input string htag);
    int ia, ib;
    @(negedge clk);
    drive(mag, deg, alt, ia, ib);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R7", "done early", int'(done), 0);
    @(negedge clk);
    compare(ia, ib, alt, htag);
    @(negedge clk);
    chk(done == 1'b0, "R7", "done width", int'(done), 0);
  endtask

  task automatic t_reset();
    chk(done == 1'b0, "R9", "done", int'(done), 0);
    chk(hex_idx == 3'd0, "R9", "hex_idx", int'(hex_idx), 0);
    chk(sector == 3'd0, "R9", "sector", int'(sector), 0);
    chk(t_a == '0 && t_b == '0 && t_z == '0, "R9", "dwell", int'(t_a) + int'(t_b) + int'(t_z), 0);
  endtask

  task automatic t_six_hex();
    for (int j = 0; j < 6; j++) run_point(1.3, 10.0 + 60.0 * j, 1'b0, "R1");
    run_point(1.5, 0.0, 1'b0, "R1");
    chk(t_a >= 16'd497 && t_a <= 16'd503, "R5", "half vector t_a", int'(t_a), 500);
  endtask

  task automatic t_inner();
    run_point(0.3, 100.0, 1'b0, "R1");
    chk(hex_idx == 3'd3, "R1", "inner hex", int'(hex_idx), 3);
    run_point(0.6, 200.0, 1'b0, "R1");
    chk(hex_idx == 3'd4, "R1", "inner hex", int'(hex_idx), 4);
  endtask

  task automatic t_override_legal();
    run_point(1.2, 20.0, 1'b0, "R1");
    chk(hex_idx == 3'd1, "R1", "overlap default", int'(hex_idx), 1);
    run_point(1.2, 20.0, 1'b1, "R2");
    chk(hex_idx == 3'd2, "R2", "overlap override up", int'(hex_idx), 2);
    run_point(1.2, 200.0, 1'b1, "R2");
    chk(hex_idx == 3'd5, "R2", "overlap override", int'(hex_idx), 5);
    run_point(0.3, 100.0, 1'b1, "R2");
    chk(hex_idx == 3'd2, "R2", "inner override down", int'(hex_idx), 2);
  endtask

  task automatic t_override_illegal();
    run_point(1.5, 0.0, 1'b1, "R3");
    chk(hex_idx == 3'd1, "R3", "refused override", int'(hex_idx), 1);
    run_point(1.8, 3.0, 1'b1, "R3");
    chk(hex_idx == 3'd1, "R3", "refused override", int'(hex_idx), 1);
  endtask

  task automatic t_saturate();
    run_point(1.95, 5.0, 1'b0, "R1");
    chk(t_z == '0, "R6", "zero time saturated", int'(t_z), 0);
  endtask

  task automatic t_stream_and_hold();
    int ia0, ib0, ia1, ib1;
    logic [2:0] h, s;
    logic [TW-1:0] a, b, z;
    @(negedge clk);
    drive(1.3, 130.0, 1'b0, ia0, ib0);
    @(negedge clk);
    drive(1.3, 250.0, 1'b0, ia1, ib1);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    compare(ia0, ib0, 1'b0, "R1");
    @(negedge clk);
    compare(ia1, ib1, 1'b0, "R1");
    h = hex_idx; s = sector; a = t_a; b = t_b; z = t_z;
    ref_alpha = 16'sd300;
    ref_beta  = -16'sd900;
    alt_sel   = 1'b1;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      chk(done == 1'b0, "R8", "no strobe no done", int'(done), 0);
    end
    chk(hex_idx == h && sector == s, "R8", "index/sector held", int'({hex_idx, sector}), int'({h, s}));
    chk(t_a == a && t_b == b && t_z == z, "R8", "dwell held", int'(t_a), int'(a));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_six_hex();
    t_inner();
    t_override_legal();
    t_override_illegal();
    t_saturate();
    t_stream_and_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule